// File: doc/BRIEF.md
# Masked Vector Load/Store Unit

This unit executes conditional packed memory moves for a 256-bit vector datapath. A one-cycle start pulse hands it an operation code, an element-width field, a vector-length select (128 or 256 bits), a mask vector, a store data vector and a byte base address. Each element is enabled by the sign bit of its slot in the mask vector. The unit then walks through the enabled elements one at a time over a simple request/response memory port and skips every disabled one. For loads it assembles a result vector. For stores it writes only the enabled elements.

Memory accesses are issued one at a time, from the lowest enabled element up, and a request waits for its response before the next one goes out. A response may carry a fault flag. A fault ends the operation at once. The unit then reports the index of the element that faulted and leaves the result register as it was. An operation code that is not one of the four legal ones, or an element-width field of 1, is rejected without any memory traffic. Every outcome is signalled by a done pulse exactly one cycle long.

Top module: `maskvec_lsu`

## Requirements
- R1: Element i is enabled only by the most significant bit of its mask slot: bit 32*i+31 for 32-bit elements and bit 64*i+63 for 64-bit elements. All other mask bits have no effect.
- R2: On a successful load, each enabled lane of `result_vec` holds the little-endian bytes read at that element's address, and each disabled lane is zero. A 32-bit element takes `mem_rdata[31:0]`. The result register is updated in the same cycle as the done pulse.
- R3: A store issues one write per enabled element and none for disabled elements. A 32-bit element carries its data in `mem_wdata[31:0]` with `mem_be` = 0x0F. A 64-bit element uses all of `mem_wdata` with `mem_be` = 0xFF. Bytes of disabled elements and neighbouring bytes are left unchanged.
- R4: Element i is accessed at `base_addr` + 4*i (32-bit elements) or `base_addr` + 8*i (64-bit elements). Enabled elements are accessed in ascending index order, with at most one request outstanding at a time.
- R5: When no element is enabled, the operation completes with no memory request and no fault. A load in this case returns an all-zero `result_vec`.
- R6: Opcode 0x2C is a 32-bit load, 0x2D a 64-bit load, 0x2E a 32-bit store and 0x2F a 64-bit store, each with `elem_w` = 0. Any other opcode, or `elem_w` = 1, gives `done` together with `err_opcode` in the cycle after start. It issues no request and leaves `result_vec` unchanged.
- R7: A response with `mem_rsp_fault` set stops the unit and no further request is issued. The unit raises `fault` with `done` and sets `fault_idx` to the faulting element's index. `result_vec` keeps its previous value, and store elements before the fault stay written.
- R8: Base addresses are not checked for alignment. An unaligned base gives the same accesses as any other base, and no fault is raised.
- R9: `start` is taken only while `busy` is low, and a start pulse during an operation is ignored. Each accepted operation gives exactly one `done` pulse, one cycle wide. After reset the unit is idle, with no request and a zero result.
- R10: With `vec256` = 0, only the low 4 (32-bit) or 2 (64-bit) elements are considered. Mask bits at positions 128 and above are ignored, and a load result is zero in bits 255:128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken when idle |
| opcode | input | 8 | Operation code (0x2C..0x2F legal) |
| elem_w | input | 1 | Element-width field, must be 0 |
| vec256 | input | 1 | 1 = 256-bit vector, 0 = 128-bit |
| mask_vec | input | 256 | Mask vector, sign bit of each element enables it |
| store_vec | input | 256 | Data vector for stores |
| base_addr | input | 32 | Byte base address |
| mem_req | output | 1 | One-cycle memory request strobe |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Write byte enables |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rdata | input | 64 | Read data (little-endian) |
| mem_rsp_fault | input | 1 | Response carries a fault |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_opcode | output | 1 | Invalid-opcode flag, valid with done |
| fault | output | 1 | Memory fault flag, valid with done |
| fault_idx | output | 3 | Index of the faulting element |
| result_vec | output | 256 | Load result register |

## Verification
The tests aim at mask patterns that set low-order bits but clear sign bits. A design that takes the wrong bit as the enable would issue requests for those elements. 128-bit tests also set mask bits above 127 to catch leakage into the upper half, and a design with that fault would issue extra requests or leave nonzero upper result bits. Fault tests inject the fault mid-sequence on both a load and a store: a unit that keeps going, or commits partial load data, would show extra requests or a changed result. Stores are checked byte by byte against a model of memory, so a wrong byte enable or a write for a disabled element shows up as a corrupted neighbour. Further tests cover an unaligned base, the rejected operation codes, and a start pulse given while busy, which a careless FSM would take as a second operation.

// File: rtl/mvl_pkg.sv
package mvl_pkg;

    localparam logic [7:0] OP_GROUP = 8'h2C;   // 0x2C..0x2F
    localparam int         BE_W     = 8;

    typedef struct packed {
        logic legal;
        logic is_store;
        logic is_dbl;
    } mvl_op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } mvl_state_t;

    function automatic logic [BE_W-1:0] lane_be(input logic dbl);
        return dbl ? 8'hFF : 8'h0F;
    endfunction

endpackage

// File: rtl/mvl_decode.sv
module mvl_decode
    import mvl_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       elem_w,
    output mvl_op_t    op
);
    always_comb begin
        op.legal    = ((opcode & 8'hFC) == OP_GROUP) && !elem_w;
        op.is_store = opcode[1];
        op.is_dbl   = opcode[0];
    end
endmodule

// File: rtl/mvl_lane_en.sv
module mvl_lane_en #(
    parameter int VEC_W = 256,
    localparam int LANES = VEC_W / 32
) (
    input  logic [VEC_W-1:0] mask_vec,
    input  logic             is_dbl,
    input  logic             vec256,
    output logic [LANES-1:0] lane_en
);
    logic [LANES-1:0] sgl_en;
    logic [LANES-1:0] dbl_en;

    for (genvar i = 0; i < LANES; i++) begin : g_sgl
        if (i < LANES / 2) begin : g_lo
            assign sgl_en[i] = mask_vec[32*i+31];
        end else begin : g_hi
            assign sgl_en[i] = mask_vec[32*i+31] & vec256;
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_dbl
        if (j < LANES / 4) begin : g_lo
            assign dbl_en[j] = mask_vec[64*j+63];
        end else if (j < LANES / 2) begin : g_hi
            assign dbl_en[j] = mask_vec[64*j+63] & vec256;
        end else begin : g_none
            assign dbl_en[j] = 1'b0;
        end
    end

    assign lane_en = is_dbl ? dbl_en : sgl_en;
endmodule

// File: rtl/mvl_engine.sv
module mvl_engine
    import mvl_pkg::*;
#(
    parameter int VEC_W = 256,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int LANES = VEC_W / 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  mvl_op_t          op,
    input  logic [LANES-1:0] lane_en,
    input  logic [VEC_W-1:0] store_vec,
    input  logic [AW-1:0]    base_addr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic [BE_W-1:0]  mem_be,
    input  logic             mem_rsp_valid,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_rsp_fault,
    output logic             busy,
    output logic             done,
    output logic             err_opcode,
    output logic             fault,
    output logic [IDX_W-1:0] fault_idx,
    output logic [VEC_W-1:0] result_vec
);
    mvl_state_t       state;
    logic [LANES-1:0] pend, pend_nxt;
    logic             dbl_q, st_q;
    logic [AW-1:0]    base_q;
    logic [VEC_W-1:0] sdata_q, acc, acc_nxt;
    logic [IDX_W-1:0] cur;

    // lowest pending element
    always_comb begin
        cur = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) cur = IDX_W'(i);
        end
        pend_nxt = pend;
        pend_nxt[cur] = 1'b0;
    end

    // request fields and load merge
    always_comb begin
        mem_wdata = '0;
        acc_nxt   = acc;
        for (int i = 0; i < LANES; i++) begin
            if (!dbl_q && cur == IDX_W'(i)) begin
                mem_wdata[31:0]   = sdata_q[32*i +: 32];
                acc_nxt[32*i +: 32] = mem_rdata[31:0];
            end
        end
        for (int j = 0; j < LANES / 2; j++) begin
            if (dbl_q && cur == IDX_W'(j)) begin
                mem_wdata            = sdata_q[64*j +: 64];
                acc_nxt[64*j +: 64]  = mem_rdata;
            end
        end
    end

    assign mem_req  = (state == ST_REQ);
    assign mem_we   = st_q;
    assign mem_be   = st_q ? lane_be(dbl_q) : '0;
    assign mem_addr = base_q + (AW'(cur) << (dbl_q ? 3 : 2));
    assign busy     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            pend       <= '0;
            dbl_q      <= 1'b0;
            st_q       <= 1'b0;
            base_q     <= '0;
            sdata_q    <= '0;
            acc        <= '0;
            done       <= 1'b0;
            err_opcode <= 1'b0;
            fault      <= 1'b0;
            fault_idx  <= '0;
            result_vec <= '0;
        end else begin
            done       <= 1'b0;
            err_opcode <= 1'b0;
            fault      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (!op.legal) begin
                            done       <= 1'b1;
                            err_opcode <= 1'b1;
                        end else if (lane_en == '0) begin
                            done <= 1'b1;
                            if (!op.is_store) result_vec <= '0;
                        end else begin
                            state   <= ST_REQ;
                            pend    <= lane_en;
                            dbl_q   <= op.is_dbl;
                            st_q    <= op.is_store;
                            base_q  <= base_addr;
                            sdata_q <= store_vec;
                            acc     <= '0;
                        end
                    end
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_fault) begin
                            state     <= ST_IDLE;
                            pend      <= '0;
                            done      <= 1'b1;
                            fault     <= 1'b1;
                            fault_idx <= cur;
                        end else begin
                            pend <= pend_nxt;
                            if (!st_q) acc <= acc_nxt;
                            if (pend_nxt == '0) begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                                if (!st_q) result_vec <= acc_nxt;
                            end else begin
                                state <= ST_REQ;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/maskvec_lsu.sv
module maskvec_lsu
    import mvl_pkg::*;
#(
    parameter int VEC_W = 256,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int LANES = VEC_W / 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic             elem_w,
    input  logic             vec256,
    input  logic [VEC_W-1:0] mask_vec,
    input  logic [VEC_W-1:0] store_vec,
    input  logic [AW-1:0]    base_addr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic [7:0]       mem_be,
    input  logic             mem_rsp_valid,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_rsp_fault,
    output logic             busy,
    output logic             done,
    output logic             err_opcode,
    output logic             fault,
    output logic [IDX_W-1:0] fault_idx,
    output logic [VEC_W-1:0] result_vec
);
    mvl_op_t          op;
    logic [LANES-1:0] lane_en;

    mvl_decode u_dec (
        .opcode (opcode),
        .elem_w (elem_w),
        .op     (op)
    );

    mvl_lane_en #(.VEC_W(VEC_W)) u_en (
        .mask_vec (mask_vec),
        .is_dbl   (op.is_dbl),
        .vec256   (vec256),
        .lane_en  (lane_en)
    );

    mvl_engine #(.VEC_W(VEC_W), .AW(AW), .DW(DW)) u_eng (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .op            (op),
        .lane_en       (lane_en),
        .store_vec     (store_vec),
        .base_addr     (base_addr),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_be        (mem_be),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rdata     (mem_rdata),
        .mem_rsp_fault (mem_rsp_fault),
        .busy          (busy),
        .done          (done),
        .err_opcode    (err_opcode),
        .fault         (fault),
        .fault_idx     (fault_idx),
        .result_vec    (result_vec)
    );
endmodule

// File: rtl/mvl_checker.sv
module mvl_checker #(
    parameter int VEC_W = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [7:0]       opcode,
    input logic             elem_w,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_we,
    input logic [7:0]       mem_be,
    input logic             done,
    input logic             err_opcode,
    input logic             fault,
    input logic [VEC_W-1:0] result_vec
);
    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: one request at a time, never back to back
    p_single_req_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    p_req_busy_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R3: store byte enables cover exactly one element
    p_store_be_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_be == 8'h0F || mem_be == 8'hFF));

    // R6: illegal code or width field rejected in the next cycle
    p_bad_op_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (((opcode & 8'hFC) != 8'h2C) || elem_w))
        |=> (done && err_opcode && !busy));

    p_err_done_r6: assert property (@(posedge clk) disable iff (rst)
        err_opcode |-> (done && !fault));

    // R7: fault only reported with completion
    p_fault_done_r7: assert property (@(posedge clk) disable iff (rst)
        fault |-> (done && !busy));

    // R7: result register changes only at completion
    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_vec) |-> (done && !fault && !err_opcode));
endmodule

bind maskvec_lsu mvl_checker #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .opcode     (opcode),
    .elem_w     (elem_w),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .done       (done),
    .err_opcode (err_opcode),
    .fault      (fault),
    .result_vec (result_vec)
);

// File: tb/maskvec_lsu_test.sv
module maskvec_lsu_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [7:0]   opcode = 8'h2C;
    logic         elem_w = 1'b0;
    logic         vec256 = 1'b1;
    logic [255:0] mask_vec = '0;
    logic [255:0] store_vec = '0;
    logic [31:0]  base_addr = '0;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [63:0]  mem_wdata;
    logic [7:0]   mem_be;
    logic         mem_rsp_valid = 1'b0;
    logic [63:0]  mem_rdata = '0;
    logic         mem_rsp_fault = 1'b0;
    logic         busy, done, err_opcode, fault;
    logic [2:0]   fault_idx;
    logic [255:0] result_vec;

    always #5 clk = ~clk;

    maskvec_lsu uut (.*);

    int n_tests = 0, n_fail = 0;
    logic [7:0]  mbytes [256];
    logic [7:0]  xbytes [256];
    int          req_n;
    logic [31:0] req_addr [16];
    logic [7:0]  req_be   [16];
    int          done_cnt = 0;
    bit          flt_on = 0;
    logic [31:0] flt_addr = '0;
    bit          lat = 0;
    logic [63:0] rd_hold;
    bit          flt_hold;
    bit          g_done, g_err, g_flt;
    logic [2:0]  g_idx;

    // memory responder: one cycle latency, driven on falling edge
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_fault = 1'b0;
        if (lat) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_fault = flt_hold;
            mem_rdata     = rd_hold;
            lat = 0;
        end
        if (done) done_cnt++;
        if (mem_req) begin
            if (req_n < 16) begin
                req_addr[req_n] = mem_addr;
                req_be[req_n]   = mem_be;
            end
            req_n++;
            flt_hold = flt_on && (mem_addr == flt_addr);
            for (int k = 0; k < 8; k++) rd_hold[8*k +: 8] = mbytes[8'(mem_addr + 32'(k))];
            if (mem_we && !flt_hold)
                for (int k = 0; k < 8; k++)
                    if (mem_be[k]) mbytes[8'(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];
            lat = 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_load(bit dbl, bit v256, logic [255:0] m, logic [31:0] base);
        logic [255:0] r = '0;
        int sz = dbl ? 8 : 4;
        int n  = (v256 ? 32 : 16) / sz;
        for (int i = 0; i < n; i++)
            if (m[i*sz*8 + sz*8 - 1])
                for (int k = 0; k < sz; k++)
                    r[(i*sz+k)*8 +: 8] = mbytes[8'(base + 32'(i*sz + k))];
        return r;
    endfunction

    // expected request count/addresses; stop = lane index where a fault hits
    task automatic check_reqs(string req, bit dbl, bit v256, logic [255:0] m, logic [31:0] base, int stop);
        int sz = dbl ? 8 : 4;
        int n  = (v256 ? 32 : 16) / sz;
        int e  = 0;
        bit ok = 1;
        for (int i = 0; i < n && i <= stop; i++)
            if (m[i*sz*8 + sz*8 - 1]) begin
                if (e < req_n && e < 16 && req_addr[e] != base + 32'(i*sz)) ok = 0;
                e++;
            end
        check(ok && (e == req_n), req, 256'(req_n), 256'(e));
    endtask

    task automatic model_store(bit dbl, bit v256, logic [255:0] m, logic [255:0] d, logic [31:0] base, int stop);
        int sz = dbl ? 8 : 4;
        int n  = (v256 ? 32 : 16) / sz;
        for (int i = 0; i < n && i < stop; i++)
            if (m[i*sz*8 + sz*8 - 1])
                for (int k = 0; k < sz; k++)
                    xbytes[8'(base + 32'(i*sz + k))] = d[(i*sz+k)*8 +: 8];
    endtask

    task automatic check_mem(string req);
        int bad = 0;
        for (int a = 0; a < 256; a++) if (mbytes[a] !== xbytes[a]) bad++;
        check(bad == 0, req, 256'(bad), 256'(0));
    endtask

    task automatic run_op(logic [7:0] oc, bit w, bit v256, logic [255:0] m, logic [255:0] d, logic [31:0] base);
        @(negedge clk);
        opcode = oc; elem_w = w; vec256 = v256; mask_vec = m; store_vec = d; base_addr = base;
        req_n = 0; g_done = 0; g_err = 0; g_flt = 0; g_idx = '0;
        for (int a = 0; a < 256; a++) xbytes[a] = mbytes[a];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (done) begin
                g_done = 1; g_err = err_opcode; g_flt = fault; g_idx = fault_idx;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(!busy && !done && !mem_req && result_vec == '0, "R9 reset state",
              {busy, done, mem_req}, 0);
    endtask

    task automatic t_load_sgl256();
        logic [255:0] m = '0, e;
        m[31] = 1; m[95] = 1; m[255] = 1; m[62] = 1; m[63-32] = 1;
        m[30] = 1; m[32+30] = 1;
        e = exp_load(0, 1, m, 32'h20);
        run_op(8'h2C, 0, 1, m, '0, 32'h20);
        check(g_done && !g_err && !g_flt && result_vec == e, "R2 load single 256", result_vec, e);
        check_reqs("R1 R4 sign-bit enables, ascending addresses", 0, 1, m, 32'h20, 99);
    endtask

    task automatic t_load_dbl128();
        logic [255:0] m = '0, e;
        m[63] = 1; m[127] = 1; m[191] = 1; m[255] = 1;
        e = exp_load(1, 0, m, 32'h40);
        run_op(8'h2D, 0, 0, m, '0, 32'h40);
        check(result_vec == e && result_vec[255:128] == '0, "R10 load double 128 upper zero", result_vec, e);
        check_reqs("R10 only low lanes accessed", 1, 0, m, 32'h40, 99);
    endtask

    task automatic t_load_dbl256();
        logic [255:0] m = '0, e;
        m[127] = 1; m[255] = 1; m[62] = 1;
        e = exp_load(1, 1, m, 32'h50);
        run_op(8'h2D, 0, 1, m, '0, 32'h50);
        check(result_vec == e, "R2 load double 256", result_vec, e);
        check_reqs("R4 double stride 8", 1, 1, m, 32'h50, 99);
    endtask

    task automatic t_zero_mask();
        logic [255:0] m = {8{32'h7FFF_FFFF}};
        run_op(8'h2C, 0, 1, m, '0, 32'h10);
        check(g_done && !g_flt && !g_err && req_n == 0 && result_vec == '0,
              "R5 zero mask no access", 256'(req_n), 0);
    endtask

    task automatic t_store_sgl128();
        logic [255:0] m = '0, d;
        bit ok = 1;
        logic [255:0] r0 = result_vec;
        m[63] = 1; m[127] = 1; m[191] = 1; m[31] = 0; m[30] = 1;
        for (int i = 0; i < 8; i++) d[32*i +: 32] = 32'hC0DE_0000 + 32'(i);
        run_op(8'h2E, 0, 0, m, d, 32'h80);
        model_store(0, 0, m, d, 32'h80, 99);
        check_mem("R3 store single 128 bytes");
        for (int i = 0; i < req_n && i < 16; i++) if (req_be[i] != 8'h0F) ok = 0;
        check(ok && req_n == 2, "R3 single byte enables", 256'(req_be[0]), 256'(8'h0F));
        check(result_vec == r0, "R3 store leaves result", result_vec, r0);
    endtask

    task automatic t_store_dbl_unaligned();
        logic [255:0] m = '0, d;
        bit ok = 1;
        m[63] = 1; m[127] = 1; m[191] = 1; m[255] = 1;
        for (int i = 0; i < 4; i++) d[64*i +: 64] = 64'h1122_3344_5566_7700 + 64'(i);
        run_op(8'h2F, 0, 1, m, d, 32'hA3);
        model_store(1, 1, m, d, 32'hA3, 99);
        check(g_done && !g_flt, "R8 unaligned base no fault", 256'(g_flt), 0);
        check_mem("R8 unaligned double store bytes");
        check_reqs("R8 unaligned addresses", 1, 1, m, 32'hA3, 99);
        for (int i = 0; i < req_n && i < 16; i++) if (req_be[i] != 8'hFF) ok = 0;
        check(ok, "R3 double byte enables", 256'(req_be[0]), 256'(8'hFF));
    endtask

    task automatic t_bad_ops();
        logic [255:0] r0 = result_vec;
        run_op(8'h2C, 1, 1, '1, '0, 32'h0);
        check(g_done && g_err && req_n == 0 && result_vec == r0, "R6 width field 1 rejected",
              256'(req_n), 0);
        run_op(8'h2B, 0, 1, '1, '0, 32'h0);
        check(g_done && g_err && req_n == 0, "R6 opcode 0x2B rejected", 256'(g_err), 1);
        run_op(8'h30, 0, 1, '1, '0, 32'h0);
        check(g_done && g_err && req_n == 0 && result_vec == r0, "R6 opcode 0x30 rejected",
              256'(g_err), 1);
    endtask

    task automatic t_load_fault();
        logic [255:0] r0 = result_vec;
        flt_on = 1; flt_addr = 32'h10 + 32'd20;
        run_op(8'h2C, 0, 1, '1, '0, 32'h10);
        flt_on = 0;
        check(g_done && g_flt && !g_err && g_idx == 3'd5, "R7 load fault index", 256'(g_idx), 5);
        check(result_vec == r0, "R7 load fault result unchanged", result_vec, r0);
        check_reqs("R7 load fault stops requests", 0, 1, '1, 32'h10, 5);
    endtask

    task automatic t_store_fault();
        logic [255:0] d;
        for (int i = 0; i < 8; i++) d[32*i +: 32] = 32'hFACE_0000 + 32'(i);
        flt_on = 1; flt_addr = 32'hC0 + 32'd16;
        run_op(8'h2F, 0, 1, '1, d, 32'hC0);
        flt_on = 0;
        model_store(1, 1, '1, d, 32'hC0, 2);
        check(g_flt && g_idx == 3'd2, "R7 store fault index", 256'(g_idx), 2);
        check_mem("R7 store fault memory");
        check_reqs("R7 store fault stops requests", 1, 1, '1, 32'hC0, 2);
    endtask

    task automatic t_busy_start();
        logic [255:0] m = '0;
        int dc0;
        m[31] = 1; m[63] = 1; m[95] = 1;
        @(negedge clk);
        dc0 = done_cnt;
        opcode = 8'h2C; elem_w = 0; vec256 = 1; mask_vec = m; base_addr = 32'h0;
        req_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        opcode = 8'h2F; mask_vec = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        check(done_cnt == dc0 + 1 && req_n == 3, "R9 start ignored while busy",
              256'(req_n), 3);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) mbytes[a] = 8'(a * 7 + 3);
        req_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_sgl256();
        t_load_dbl128();
        t_load_dbl256();
        t_zero_mask();
        t_store_sgl128();
        t_store_dbl_unaligned();
        t_load_sgl256();
        t_bad_ops();
        t_load_fault();
        t_store_fault();
        t_busy_start();
        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule